// File: doc/BRIEF.md
# Reset Cause Status Register

This block holds the sticky flags that software reads after start-up to learn which reset or wake-up event came last. A power-control byte carries a power-on flag, a brown-out flag, an ultra-low-power wake-up enable and a software brown-out enable. Two further status flags, time-out (TO) and power-down (PD), record watchdog and sleep history. Each event changes only the bits it owns and leaves the rest alone. After software has set the power-on and brown-out flags to 1, a 0 found in either flag on a later reset points to that kind of event.

The surrounding logic delivers single-cycle event strobes: brown-out, watchdog reset, watchdog wake-up, master clear (qualified by an in-sleep input), wake-up reset, sleep entry and clear-watchdog. The power-on reset itself is the asynchronous active-low `por_n`. A two-bit brown-out mode input selects when brown-out strobes count. Software writes the power-control byte through a plain write strobe. There is no stream interface, so no valid/ready handshake and no back-pressure: a write is taken in the cycle its strobe is high, or it is discarded under the priority rule.

Top module: `rcs_status_top`

## Requirements
- R1: While `por_n` is low, POR flag (bit 1) is 0, BOR flag (bit 0) equals parameter BOR_AFTER_POR, ULP enable (bit 5) is 0, software BOR enable (bit 4) is 1, `stat_to` and `stat_pd` are 1 and the asleep state is cleared.
- R2: Power-control bits 7:6 and 3:2 always read 0. Bits 5 and 4 take `wr_data[5]` and `wr_data[4]` on the edge where an accepted write is seen.
- R3: Bits 1 and 0 are write-one-to-set: a written 1 sets the flag and a written 0 has no effect. The POR flag is cleared only by power-on reset.
- R4: An armed brown-out strobe clears the BOR flag, clears bit 5, sets bit 4, sets TO and PD, clears asleep and leaves the POR flag unchanged.
- R5: `bor_armed` is 1 in mode 11, 1 in mode 10 when not asleep, equal to bit 4 in mode 01, and 0 in mode 00. A brown-out strobe that is not armed has no effect on any output.
- R6: A watchdog reset clears TO and leaves PD unchanged. A watchdog wake-up clears both TO and PD.
- R7: A master clear with `mclr_in_sleep`=0 leaves TO and PD unchanged. With `mclr_in_sleep`=1 it sets TO and clears PD. A wake-up reset acts the same as a master clear in sleep. All of these clear asleep.
- R8: Sleep entry sets TO, clears PD and marks the block asleep. Clear-watchdog sets TO and PD.
- R9: Among coincident events, the priority is armed brown-out, then watchdog wake-up, watchdog reset, master clear, wake-up reset, clear-watchdog and sleep entry. A write is discarded in a cycle that carries a brown-out, watchdog, master-clear or wake-up-reset event, and is applied otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| bor_mode | input | 2 | Brown-out mode: 00 off, 01 software, 10 run only, 11 always |
| bor_evt | input | 1 | Brown-out strobe |
| wdt_rst_evt | input | 1 | Watchdog reset strobe |
| wdt_wake_evt | input | 1 | Watchdog wake-up strobe |
| mclr_evt | input | 1 | Master-clear strobe |
| mclr_in_sleep | input | 1 | Qualifier: master clear arrived during sleep |
| wake_rst_evt | input | 1 | Wake-up reset strobe |
| sleep_evt | input | 1 | Sleep-entry strobe |
| clrwdt_evt | input | 1 | Clear-watchdog strobe |
| wr_en | input | 1 | Power-control write strobe |
| wr_data | input | REG_W | Power-control write data |
| pcon_rd | output | REG_W | Power-control read value |
| stat_to | output | 1 | Time-out flag |
| stat_pd | output | 1 | Power-down flag |
| bor_armed | output | 1 | Brown-out strobes currently take effect |

## Verification
The bench builds the block with BOR_AFTER_POR = 1 and REG_W = 8. Because the brown-out flag then powers up at 1 and not at 0, a 0 seen after a brown-out can only come from the brown-out path, and a power-on reset must restore the 1. The eight-bit width places the reserved bits on both sides of the live fields, so a stray write into bits 7:6 or 3:2 shows up. Every brown-out mode is driven into its armed and unarmed states, including run-only mode while asleep, and coincident strobes exercise each step of the priority chain.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  localparam int POS_BOR  = 0;
  localparam int POS_POR  = 1;
  localparam int POS_SBOR = 4;
  localparam int POS_ULP  = 5;

  localparam logic [1:0] BORM_OFF = 2'b00;
  localparam logic [1:0] BORM_SW  = 2'b01;
  localparam logic [1:0] BORM_RUN = 2'b10;
  localparam logic [1:0] BORM_ON  = 2'b11;

  typedef enum logic [3:0] {
    EV_NONE,
    EV_BOR,
    EV_WDT_WAKE,
    EV_WDT_RST,
    EV_MCLR_RUN,
    EV_MCLR_SLP,
    EV_WAKE_RST,
    EV_CLRWDT,
    EV_SLEEP
  } rcs_evt_e;

  function automatic logic evt_blocks_write(rcs_evt_e e);
    case (e)
      EV_BOR, EV_WDT_WAKE, EV_WDT_RST,
      EV_MCLR_RUN, EV_MCLR_SLP, EV_WAKE_RST: evt_blocks_write = 1'b1;
      default:                               evt_blocks_write = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rcs_bor_gate.sv
module rcs_bor_gate
  import rcs_pkg::*;
(
  input  logic [1:0] bor_mode,
  input  logic       sboren,
  input  logic       asleep,
  input  logic       bor_evt,
  output logic       bor_armed,
  output logic       bor_live
);

  always_comb begin
    case (bor_mode)
      BORM_ON:  bor_armed = 1'b1;
      BORM_RUN: bor_armed = ~asleep;
      BORM_SW:  bor_armed = sboren;
      default:  bor_armed = 1'b0;
    endcase
  end

  assign bor_live = bor_evt & bor_armed;

endmodule

// File: rtl/rcs_evt_arb.sv
module rcs_evt_arb
  import rcs_pkg::*;
(
  input  logic     bor_live,
  input  logic     wdt_wake_evt,
  input  logic     wdt_rst_evt,
  input  logic     mclr_evt,
  input  logic     mclr_in_sleep,
  input  logic     wake_rst_evt,
  input  logic     clrwdt_evt,
  input  logic     sleep_evt,
  input  logic     wr_en,
  output rcs_evt_e evt,
  output logic     wr_ok
);

  always_comb begin
    if (bor_live)          evt = EV_BOR;
    else if (wdt_wake_evt) evt = EV_WDT_WAKE;
    else if (wdt_rst_evt)  evt = EV_WDT_RST;
    else if (mclr_evt)     evt = mclr_in_sleep ? EV_MCLR_SLP : EV_MCLR_RUN;
    else if (wake_rst_evt) evt = EV_WAKE_RST;
    else if (clrwdt_evt)   evt = EV_CLRWDT;
    else if (sleep_evt)    evt = EV_SLEEP;
    else                   evt = EV_NONE;
  end

  assign wr_ok = wr_en & ~evt_blocks_write(evt);

endmodule

// File: rtl/rcs_sleep_flags.sv
module rcs_sleep_flags
  import rcs_pkg::*;
(
  input  logic     clk,
  input  logic     por_n,
  input  rcs_evt_e evt,
  output logic     to_q,
  output logic     pd_q,
  output logic     asleep_q
);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      to_q     <= 1'b1;
      pd_q     <= 1'b1;
      asleep_q <= 1'b0;
    end else begin
      case (evt)
        EV_BOR: begin
          to_q     <= 1'b1;
          pd_q     <= 1'b1;
          asleep_q <= 1'b0;
        end
        EV_WDT_WAKE: begin
          to_q     <= 1'b0;
          pd_q     <= 1'b0;
          asleep_q <= 1'b0;
        end
        EV_WDT_RST: begin
          to_q     <= 1'b0;
          asleep_q <= 1'b0;
        end
        EV_MCLR_RUN: begin
          asleep_q <= 1'b0;
        end
        EV_MCLR_SLP, EV_WAKE_RST: begin
          to_q     <= 1'b1;
          pd_q     <= 1'b0;
          asleep_q <= 1'b0;
        end
        EV_CLRWDT: begin
          to_q <= 1'b1;
          pd_q <= 1'b1;
        end
        EV_SLEEP: begin
          to_q     <= 1'b1;
          pd_q     <= 1'b0;
          asleep_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rcs_pcon_reg.sv
module rcs_pcon_reg
  import rcs_pkg::*;
#(
  parameter int   REG_W         = 8,
  parameter logic BOR_AFTER_POR = 1'b0
) (
  input  logic             clk,
  input  logic             por_n,
  input  rcs_evt_e         evt,
  input  logic             wr_ok,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd,
  output logic             sboren
);

  logic ulp_q, sbor_q, por_q, bor_q;
  logic unused_wr;

  assign unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ulp_q  <= 1'b0;
      sbor_q <= 1'b1;
      por_q  <= 1'b0;
      bor_q  <= BOR_AFTER_POR;
    end else if (evt == EV_BOR) begin
      ulp_q  <= 1'b0;
      sbor_q <= 1'b1;
      bor_q  <= 1'b0;
    end else if (wr_ok) begin
      ulp_q  <= wr_data[POS_ULP];
      sbor_q <= wr_data[POS_SBOR];
      if (wr_data[POS_POR]) por_q <= 1'b1;
      if (wr_data[POS_BOR]) bor_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_rd
    if (i == POS_ULP) begin : g_ulp
      assign rd[i] = ulp_q;
    end else if (i == POS_SBOR) begin : g_sbor
      assign rd[i] = sbor_q;
    end else if (i == POS_POR) begin : g_por
      assign rd[i] = por_q;
    end else if (i == POS_BOR) begin : g_bor
      assign rd[i] = bor_q;
    end else begin : g_zero
      assign rd[i] = 1'b0;
    end
  end

  assign sboren = sbor_q;

endmodule

// File: rtl/rcs_status_top.sv
module rcs_status_top
  import rcs_pkg::*;
#(
  parameter int   REG_W         = 8,
  parameter logic BOR_AFTER_POR = 1'b0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [1:0]       bor_mode,
  input  logic             bor_evt,
  input  logic             wdt_rst_evt,
  input  logic             wdt_wake_evt,
  input  logic             mclr_evt,
  input  logic             mclr_in_sleep,
  input  logic             wake_rst_evt,
  input  logic             sleep_evt,
  input  logic             clrwdt_evt,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] pcon_rd,
  output logic             stat_to,
  output logic             stat_pd,
  output logic             bor_armed
);

  rcs_evt_e evt;
  logic     bor_live, wr_ok, sboren, asleep;

  rcs_bor_gate u_gate (
    .bor_mode  (bor_mode),
    .sboren    (sboren),
    .asleep    (asleep),
    .bor_evt   (bor_evt),
    .bor_armed (bor_armed),
    .bor_live  (bor_live)
  );

  rcs_evt_arb u_arb (
    .bor_live      (bor_live),
    .wdt_wake_evt  (wdt_wake_evt),
    .wdt_rst_evt   (wdt_rst_evt),
    .mclr_evt      (mclr_evt),
    .mclr_in_sleep (mclr_in_sleep),
    .wake_rst_evt  (wake_rst_evt),
    .clrwdt_evt    (clrwdt_evt),
    .sleep_evt     (sleep_evt),
    .wr_en         (wr_en),
    .evt           (evt),
    .wr_ok         (wr_ok)
  );

  rcs_sleep_flags u_flags (
    .clk      (clk),
    .por_n    (por_n),
    .evt      (evt),
    .to_q     (stat_to),
    .pd_q     (stat_pd),
    .asleep_q (asleep)
  );

  rcs_pcon_reg #(
    .REG_W         (REG_W),
    .BOR_AFTER_POR (BOR_AFTER_POR)
  ) u_pcon (
    .clk     (clk),
    .por_n   (por_n),
    .evt     (evt),
    .wr_ok   (wr_ok),
    .wr_data (wr_data),
    .rd      (pcon_rd),
    .sboren  (sboren)
  );

endmodule

// File: rtl/rcs_status_chk.sv
module rcs_status_chk
  import rcs_pkg::*;
#(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             por_n,
  input logic             bor_evt,
  input logic             bor_armed,
  input logic             wdt_rst_evt,
  input logic             wdt_wake_evt,
  input logic             mclr_evt,
  input logic             mclr_in_sleep,
  input logic             wake_rst_evt,
  input logic             sleep_evt,
  input logic             clrwdt_evt,
  input logic [REG_W-1:0] pcon_rd,
  input logic             stat_to,
  input logic             stat_pd
);

  localparam logic [REG_W-1:0] LIVE_MASK =
    (REG_W'(1) << POS_ULP) | (REG_W'(1) << POS_SBOR) |
    (REG_W'(1) << POS_POR) | (REG_W'(1) << POS_BOR);

  logic bor_hit;
  assign bor_hit = bor_evt & bor_armed;

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    (pcon_rd & ~LIVE_MASK) == '0); // R2

  AST_POR_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    !$fell(pcon_rd[POS_POR])); // R3

  AST_BOR_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    $fell(pcon_rd[POS_BOR]) |-> $past(bor_hit)); // R5

  AST_BOR_EFFECT: assert property (@(posedge clk) disable iff (!por_n)
    bor_hit |=> (!pcon_rd[POS_BOR] && pcon_rd[POS_SBOR] && stat_to && stat_pd)); // R4

  AST_WDT_RST_PD_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_rst_evt && !wdt_wake_evt && !bor_hit) |=> (!stat_to && stat_pd == $past(stat_pd))); // R6

  AST_MCLR_SLEEP: assert property (@(posedge clk) disable iff (!por_n)
    (mclr_evt && mclr_in_sleep && !bor_hit && !wdt_wake_evt && !wdt_rst_evt)
      |=> (stat_to && !stat_pd)); // R7

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
    (sleep_evt && !bor_hit && !wdt_wake_evt && !wdt_rst_evt && !mclr_evt &&
     !wake_rst_evt && !clrwdt_evt) |=> (stat_to && !stat_pd)); // R8

  AST_CLRWDT: assert property (@(posedge clk) disable iff (!por_n)
    (clrwdt_evt && !bor_hit && !wdt_wake_evt && !wdt_rst_evt && !mclr_evt &&
     !wake_rst_evt) |=> (stat_to && stat_pd)); // R9

endmodule

bind rcs_status_top rcs_status_chk #(.REG_W(REG_W)) u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .bor_evt       (bor_evt),
  .bor_armed     (bor_armed),
  .wdt_rst_evt   (wdt_rst_evt),
  .wdt_wake_evt  (wdt_wake_evt),
  .mclr_evt      (mclr_evt),
  .mclr_in_sleep (mclr_in_sleep),
  .wake_rst_evt  (wake_rst_evt),
  .sleep_evt     (sleep_evt),
  .clrwdt_evt    (clrwdt_evt),
  .pcon_rd       (pcon_rd),
  .stat_to       (stat_to),
  .stat_pd       (stat_pd)
);

// File: tb/test_rcs_status_top.sv
module test_rcs_status_top;

  localparam int CLK_PERIOD = 10;
  localparam int REG_W      = 8;

  logic             clk = 1'b0;
  logic             por_n = 1'b0;
  logic [1:0]       bor_mode = 2'b11;
  logic             bor_evt = 1'b0, wdt_rst_evt = 1'b0, wdt_wake_evt = 1'b0;
  logic             mclr_evt = 1'b0, mclr_in_sleep = 1'b0, wake_rst_evt = 1'b0;
  logic             sleep_evt = 1'b0, clrwdt_evt = 1'b0, wr_en = 1'b0;
  logic [REG_W-1:0] wr_data = '0;
  logic [REG_W-1:0] pcon_rd;
  logic             stat_to, stat_pd, bor_armed;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rcs_status_top #(.REG_W(REG_W), .BOR_AFTER_POR(1'b1)) i_rcs_status_top (
    .clk, .por_n, .bor_mode, .bor_evt, .wdt_rst_evt, .wdt_wake_evt,
    .mclr_evt, .mclr_in_sleep, .wake_rst_evt, .sleep_evt, .clrwdt_evt,
    .wr_en, .wr_data, .pcon_rd, .stat_to, .stat_pd, .bor_armed
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req, logic [7:0] p, logic to, logic pd);
    chk(req, pcon_rd, p);
    chk(req, {6'b0, stat_to, stat_pd}, {6'b0, to, pd});
  endtask

  task automatic clear_inputs();
    bor_evt = 0; wdt_rst_evt = 0; wdt_wake_evt = 0; mclr_evt = 0;
    mclr_in_sleep = 0; wake_rst_evt = 0; sleep_evt = 0; clrwdt_evt = 0;
    wr_en = 0; wr_data = '0;
  endtask

  // Inputs set by the caller at a falling edge; one rising edge captures them.
  task automatic step();
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic do_write(logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d; step();
  endtask

  task automatic apply_por();
    @(negedge clk); por_n = 0;
    repeat (2) @(negedge clk);
    por_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    apply_por();
    chk_state("R1 reset", 8'h11, 1, 1);
    chk("R5 armed in mode 11", {7'b0, bor_armed}, 8'h01);
  endtask

  task automatic t_write();
    do_write(8'hFF);
    chk("R2 R3 write ones", pcon_rd, 8'h33);
    do_write(8'h00);
    chk("R2 R3 write zeros", pcon_rd, 8'h03);
  endtask

  task automatic t_sleep_wdt();
    @(negedge clk); sleep_evt = 1; step();
    chk_state("R8 sleep entry", 8'h03, 1, 0);
    @(negedge clk); wdt_wake_evt = 1; step();
    chk_state("R6 wdt wake", 8'h03, 0, 0);
    @(negedge clk); clrwdt_evt = 1; step();
    chk_state("R8 clrwdt", 8'h03, 1, 1);
    @(negedge clk); wdt_rst_evt = 1; step();
    chk_state("R6 wdt reset", 8'h03, 0, 1);
  endtask

  task automatic t_mclr();
    @(negedge clk); mclr_evt = 1; step();
    chk_state("R7 mclr run", 8'h03, 0, 1);
    @(negedge clk); mclr_evt = 1; mclr_in_sleep = 1; step();
    chk_state("R7 mclr sleep", 8'h03, 1, 0);
    @(negedge clk); clrwdt_evt = 1; step();
    @(negedge clk); wdt_rst_evt = 1; step();
    @(negedge clk); wake_rst_evt = 1; step();
    chk_state("R7 wake reset", 8'h03, 1, 0);
  endtask

  task automatic t_bor_modes();
    bor_mode = 2'b11;
    do_write(8'h20);
    @(negedge clk); bor_evt = 1; step();
    chk_state("R4 brown-out", 8'h12, 1, 1);
    // mode 00: ignored
    bor_mode = 2'b00;
    do_write(8'h11);
    @(negedge clk); wdt_rst_evt = 1; step();
    chk("R5 armed off", {7'b0, bor_armed}, 8'h00);
    @(negedge clk); bor_evt = 1; step();
    chk_state("R5 mode 00 ignored", 8'h13, 0, 1);
    // mode 01: follows bit 4
    bor_mode = 2'b01;
    do_write(8'h01);
    chk("R5 armed sw off", {7'b0, bor_armed}, 8'h00);
    @(negedge clk); bor_evt = 1; step();
    chk_state("R5 mode 01 disabled", 8'h03, 0, 1);
    do_write(8'h10);
    chk("R5 armed sw on", {7'b0, bor_armed}, 8'h01);
    @(negedge clk); bor_evt = 1; step();
    chk_state("R5 mode 01 enabled", 8'h12, 1, 1);
    // mode 10: only while awake
    bor_mode = 2'b10;
    do_write(8'h11);
    chk("R5 armed run awake", {7'b0, bor_armed}, 8'h01);
    @(negedge clk); sleep_evt = 1; step();
    chk("R5 armed run asleep", {7'b0, bor_armed}, 8'h00);
    @(negedge clk); bor_evt = 1; step();
    chk_state("R5 mode 10 asleep ignored", 8'h13, 1, 0);
    @(negedge clk); mclr_evt = 1; mclr_in_sleep = 1; step();
    chk("R7 mclr clears asleep", {7'b0, bor_armed}, 8'h01);
    @(negedge clk); bor_evt = 1; step();
    chk_state("R4 mode 10 awake", 8'h12, 1, 1);
  endtask

  task automatic t_priority();
    bor_mode = 2'b11;
    do_write(8'h11);
    @(negedge clk); wdt_rst_evt = 1; step();
    @(negedge clk); bor_evt = 1; wdt_rst_evt = 1; step();
    chk_state("R9 bor over wdt", 8'h12, 1, 1);
    do_write(8'h11);
    @(negedge clk); wdt_rst_evt = 1; mclr_evt = 1; mclr_in_sleep = 1; step();
    chk_state("R9 wdt over mclr", 8'h13, 0, 1);
    @(negedge clk); wdt_rst_evt = 1; wr_en = 1; wr_data = 8'h20; step();
    chk("R9 write dropped", pcon_rd, 8'h13);
    @(negedge clk); sleep_evt = 1; clrwdt_evt = 1; step();
    chk_state("R9 clrwdt over sleep", 8'h13, 1, 1);
    @(negedge clk); clrwdt_evt = 1; wr_en = 1; wr_data = 8'h33; step();
    chk("R9 write with clrwdt", pcon_rd, 8'h33);
  endtask

  task automatic t_por_again();
    apply_por();
    chk_state("R1 R3 por clears flag", 8'h11, 1, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_write();
        t_sleep_wdt();
        t_mclr();
        t_bor_modes();
        t_priority();
        t_por_again();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule